// File: doc/BRIEF.md
# Processor Halt State Controller

This block sequences a processor core into and out of its low-power halted condition. When the core requests halt, the block drives a halt special bus cycle. It waits for the bus to acknowledge that cycle with bus-ready. Unless a configuration bit waives it, it then also waits for the write buffer to report empty. Only then does it drop the core clock enable and raise a halted status. A free-running time stamp counter keeps counting throughout.

While halted, the block keeps watching the wake-up inputs and the bus-side requests. An address-hold, back-off or bus-hold request moves it into an inquire-service state, and it drops straight back to halt once the request ends. A cache flush request is serviced in the same way as in normal operation. Afterwards the halt special cycle is driven again before the block re-enters halt. Any qualifying wake-up event returns the block to normal operation, and the block reports the winning cause to the core as a one-cycle, one-hot vector.

All inputs are active-high, synchronous to `clk`, and sampled on its rising edge.

Top module: `halt_ctrl`

## Requirements
- R1: A high `halt_req` in normal operation starts the halt special cycle (`halt_cyc` high from the next cycle). The cycle stays pending until `bus_rdy` is sampled high.
- R2: When `wbe_wait_off` is low at the bus-ready sample, halt is entered only after `wbuf_empty` is also sampled high. `halt_cyc` stays high until then. When `wbe_wait_off` is high, halt is entered on the cycle after bus-ready.
- R3: In the halted state `core_clk_en` is low and `halted` is high. In normal operation `core_clk_en` is high and `halted` is low.
- R4: `tsc` increments by one every cycle in every state, wrapping modulo 2^TSC_W.
- R5: Any non-normal state is left for normal on a sampled `wake_reset`, `wake_init`, `wake_smi` or `wake_nmi`. `wake_intr` wakes the block only while `int_en` is high, and otherwise has no effect.
- R6: On a wake-up, `wake_cause` is one-hot for exactly one cycle. The bits are [4] reset, [3] init, [2] smi, [1] nmi and [0] intr. When several causes are present, the highest-numbered one wins. At all other times `wake_cause` is zero.
- R7: While halted, any of `addr_hold`, `backoff` or `bus_hold` moves the block to inquire service (`inquire_busy` high). This takes precedence over a flush request. When all three are low, the block returns to halted with no new halt special cycle.
- R8: A `flush_req` while halted moves the block to flush service (`flush_busy` high). A sampled `flush_done` then reissues the halt special cycle before halt is re-entered.
- R9: `wake_reset` clears `tsc` to zero on the next edge from any state, including mid-handshake. `rst_n` low also clears `tsc` and puts the block in normal operation.
- R10: A wake-up event sampled while the halt special cycle is pending, in either handshake stage, cancels halt entry and returns the block directly to normal.
- R11: While halted, `halt_cyc` stays low and `halt_req` and `bus_rdy` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| halt_req | input | 1 | Core requests halt |
| bus_rdy | input | 1 | Bus ready for the halt special cycle |
| wbuf_empty | input | 1 | Write buffer empty handshake |
| wbe_wait_off | input | 1 | Waives the write-buffer-empty wait |
| int_en | input | 1 | Interrupts enabled in the core |
| wake_reset | input | 1 | Processor reset request |
| wake_init | input | 1 | Init request |
| wake_smi | input | 1 | System management interrupt |
| wake_nmi | input | 1 | Non-maskable interrupt |
| wake_intr | input | 1 | Maskable interrupt |
| addr_hold | input | 1 | Address hold for snooping |
| backoff | input | 1 | Bus back-off request |
| bus_hold | input | 1 | Bus hold request |
| flush_req | input | 1 | Cache flush request |
| flush_done | input | 1 | Flush operation finished |
| core_clk_en | output | 1 | Core clock enable |
| halted | output | 1 | Halted status |
| halt_cyc | output | 1 | Halt special bus cycle in progress |
| inquire_busy | output | 1 | Inquire service in progress |
| flush_busy | output | 1 | Flush service in progress |
| wake_cause | output | 5 | One-cycle one-hot wake cause |
| tsc | output | TSC_W | Time stamp counter |

## Verification
The bench builds the block with `TSC_W` set to 8. This brings the counter wrap from all ones to zero within a few hundred cycles, so the modulo behaviour of R4 is observed directly. The reset clear of R9 can then be compared against a small, known count. With this width, every handshake, service and wake path fits into one short table walk.

// File: rtl/halt_ctrl_pkg.sv
// Shared state encoding and wake-cause bit positions for the halt controller.
// Assumes: cause bit order is also the priority order (higher index wins).
package halt_ctrl_pkg;
    typedef enum logic [2:0] {
        ST_NORMAL  = 3'd0,
        ST_HSC_RDY = 3'd1,
        ST_HSC_WBE = 3'd2,
        ST_HALT    = 3'd3,
        ST_INQ     = 3'd4,
        ST_FLUSH   = 3'd5
    } hstate_e;

    localparam int CAUSE_W   = 5;
    localparam int CI_RESET  = 4;
    localparam int CI_INIT   = 3;
    localparam int CI_SMI    = 2;
    localparam int CI_NMI    = 1;
    localparam int CI_INTR   = 0;
endpackage

// File: rtl/halt_wake_arb.sv
// Fixed-priority wake arbiter: picks the highest-index asserted request.
// Assumes: inputs already qualified (intr masked by interrupt enable upstream).
module halt_wake_arb #(
    parameter int N = 5
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant,
    output logic         any
);
    // Scan from highest index down, granting the first asserted request.
    always_comb begin
        logic found;
        found = 1'b0;
        grant = '0;
        for (int i = N - 1; i >= 0; i--) begin
            grant[i] = req[i] & ~found;
            found    = found | req[i];
        end
        any = found;
    end

    // Grant must never name two causes.
    always_comb begin
        AST_GRANT_ONEHOT: assert ($onehot0(grant)); // R6
    end
endmodule

// File: rtl/halt_tsc.sv
// Free-running time stamp counter with synchronous clear.
// Assumes: clear has priority over counting; wraps modulo 2^W.
module halt_tsc #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] count
);
    // Count every cycle; block reset or clear request zero it.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) count <= '0;
        else               count <= count + 1'b1;
    end

    AST_TSC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> count == W'($past(count) + 1'b1)); // R4
    AST_TSC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> count == '0); // R9
endmodule

// File: rtl/halt_fsm.sv
// Halt sequencing state machine: handshake, halted, inquire and flush service,
// wake-up exit with a registered one-cycle cause pulse.
// Assumes: wake inputs are pre-arbitrated; wake has priority in every
// non-normal state.
module halt_fsm
    import halt_ctrl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               halt_req,
    input  logic               bus_rdy,
    input  logic               wbuf_empty,
    input  logic               wbe_wait_off,
    input  logic               snoop,
    input  logic               flush_req,
    input  logic               flush_done,
    input  logic               wake_any,
    input  logic [CAUSE_W-1:0] wake_grant,
    output hstate_e            state_q,
    output logic [CAUSE_W-1:0] cause_q
);
    hstate_e state_d;

    // Next-state selection; wake overrides everything outside normal.
    always_comb begin
        state_d = state_q;
        if (state_q != ST_NORMAL && wake_any) begin
            state_d = ST_NORMAL;
        end else begin
            unique case (state_q)
                ST_NORMAL:  if (halt_req) state_d = ST_HSC_RDY;
                ST_HSC_RDY: if (bus_rdy)  state_d = wbe_wait_off ? ST_HALT : ST_HSC_WBE;
                ST_HSC_WBE: if (wbuf_empty) state_d = ST_HALT;
                ST_HALT: begin
                    if (snoop)          state_d = ST_INQ;
                    else if (flush_req) state_d = ST_FLUSH;
                end
                ST_INQ:     if (!snoop)     state_d = ST_HALT;
                ST_FLUSH:   if (flush_done) state_d = ST_HSC_RDY;
                default:    state_d = ST_NORMAL;
            endcase
        end
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_NORMAL;
        else        state_q <= state_d;
    end

    // Cause pulse: loaded only when a wake ends a non-normal state.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   cause_q <= '0;
        else if (state_q != ST_NORMAL && wake_any)    cause_q <= wake_grant;
        else                                          cause_q <= '0;
    end

    AST_HALT_ENTRY_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT && $past(state_q) != ST_HALT) |->
        ($past(state_q) == ST_HSC_RDY || $past(state_q) == ST_HSC_WBE
         || $past(state_q) == ST_INQ)); // R1
    AST_WBE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HSC_WBE && !wbuf_empty && !wake_any) |=> state_q == ST_HSC_WBE); // R2
    AST_INQ_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_INQ && !snoop && !wake_any) |=> state_q == ST_HALT); // R7
    AST_FLUSH_REISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FLUSH && flush_done && !wake_any) |=> state_q == ST_HSC_RDY); // R8
    AST_HANDSHAKE_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_HSC_RDY || state_q == ST_HSC_WBE) && wake_any)
        |=> state_q == ST_NORMAL); // R10
endmodule

// File: rtl/halt_ctrl.sv
// Top of the halt state controller: qualifies wake sources, arbitrates them,
// runs the halt sequencer and the time stamp counter, decodes status outputs.
// Assumes: all inputs synchronous, active-high, sampled on rising clk.
module halt_ctrl
    import halt_ctrl_pkg::*;
#(
    parameter int TSC_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               halt_req,
    input  logic               bus_rdy,
    input  logic               wbuf_empty,
    input  logic               wbe_wait_off,
    input  logic               int_en,
    input  logic               wake_reset,
    input  logic               wake_init,
    input  logic               wake_smi,
    input  logic               wake_nmi,
    input  logic               wake_intr,
    input  logic               addr_hold,
    input  logic               backoff,
    input  logic               bus_hold,
    input  logic               flush_req,
    input  logic               flush_done,
    output logic               core_clk_en,
    output logic               halted,
    output logic               halt_cyc,
    output logic               inquire_busy,
    output logic               flush_busy,
    output logic [CAUSE_W-1:0] wake_cause,
    output logic [TSC_W-1:0]   tsc
);
    logic [CAUSE_W-1:0] wake_raw;
    logic [CAUSE_W-1:0] wake_grant;
    logic               wake_any;
    logic               snoop;
    hstate_e            state_q;

    // Assemble qualified wake requests in priority bit order.
    always_comb begin
        wake_raw           = '0;
        wake_raw[CI_RESET] = wake_reset;
        wake_raw[CI_INIT]  = wake_init;
        wake_raw[CI_SMI]   = wake_smi;
        wake_raw[CI_NMI]   = wake_nmi;
        wake_raw[CI_INTR]  = wake_intr & int_en;
        snoop              = addr_hold | backoff | bus_hold;
    end

    halt_wake_arb #(.N(CAUSE_W)) arb_i (
        .req   (wake_raw),
        .grant (wake_grant),
        .any   (wake_any)
    );

    halt_fsm fsm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .halt_req     (halt_req),
        .bus_rdy      (bus_rdy),
        .wbuf_empty   (wbuf_empty),
        .wbe_wait_off (wbe_wait_off),
        .snoop        (snoop),
        .flush_req    (flush_req),
        .flush_done   (flush_done),
        .wake_any     (wake_any),
        .wake_grant   (wake_grant),
        .state_q      (state_q),
        .cause_q      (wake_cause)
    );

    halt_tsc #(.W(TSC_W)) tsc_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (wake_reset),
        .count (tsc)
    );

    // Decode status outputs from the sequencer state.
    always_comb begin
        halted       = (state_q == ST_HALT);
        inquire_busy = (state_q == ST_INQ);
        flush_busy   = (state_q == ST_FLUSH);
        halt_cyc     = (state_q == ST_HSC_RDY) || (state_q == ST_HSC_WBE);
        core_clk_en  = !(halted || inquire_busy || flush_busy);
    end

    AST_HALT_GATES_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !core_clk_en); // R3
    AST_CAUSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (|wake_cause) |=> !(|wake_cause)); // R6
    AST_HALT_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && $past(halted)) |-> (!halt_cyc && $stable(halt_cyc))); // R11
endmodule

// File: tb/halt_ctrl_tb_top.sv
`timescale 1ns/1ps
module halt_ctrl_tb_top;
    localparam int TW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic halt_req, bus_rdy, wbuf_empty, wbe_wait_off, int_en;
    logic wake_reset, wake_init, wake_smi, wake_nmi, wake_intr;
    logic addr_hold, backoff, bus_hold, flush_req, flush_done;
    logic core_clk_en, halted, halt_cyc, inquire_busy, flush_busy;
    logic [4:0]    wake_cause;
    logic [TW-1:0] tsc;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    halt_ctrl #(.TSC_W(TW)) dut_i (
        .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .bus_rdy(bus_rdy),
        .wbuf_empty(wbuf_empty), .wbe_wait_off(wbe_wait_off), .int_en(int_en),
        .wake_reset(wake_reset), .wake_init(wake_init), .wake_smi(wake_smi),
        .wake_nmi(wake_nmi), .wake_intr(wake_intr), .addr_hold(addr_hold),
        .backoff(backoff), .bus_hold(bus_hold), .flush_req(flush_req),
        .flush_done(flush_done), .core_clk_en(core_clk_en), .halted(halted),
        .halt_cyc(halt_cyc), .inquire_busy(inquire_busy), .flush_busy(flush_busy),
        .wake_cause(wake_cause), .tsc(tsc)
    );

    // Input bit positions inside a vector.
    localparam logic [14:0] I_HALT = 15'h4000, I_RDY = 15'h2000, I_WBE = 15'h1000,
        I_MASK = 15'h0800, I_IEN = 15'h0400, I_RST = 15'h0200, I_INIT = 15'h0100,
        I_SMI = 15'h0080, I_NMI = 15'h0040, I_INTR = 15'h0020, I_AH = 15'h0010,
        I_BOFF = 15'h0008, I_HOLD = 15'h0004, I_FLR = 15'h0002, I_FLD = 15'h0001;
    // Expected: {clk_en, halted, halt_cyc, inquire, flush, cause[4:0]}.
    localparam logic [9:0] E_NORM = 10'b1000000000, E_HSC = 10'b1010000000,
        E_HALT = 10'b0100000000, E_INQ = 10'b0001000000, E_FLU = 10'b0000100000;
    localparam logic [9:0] C_RST = 10'd16, C_INIT = 10'd8, C_SMI = 10'd4,
        C_NMI = 10'd2, C_INTR = 10'd1;

    localparam int NV = 38;
    // {requirement number, inputs, expected outputs after one edge}
    localparam logic [28:0] VEC [NV] = '{
        {4'd3,  15'h0,                    E_NORM},          // R3 idle
        {4'd1,  I_HALT,                   E_HSC},           // R1 start
        {4'd1,  15'h0,                    E_HSC},           // R1 waits bus ready
        {4'd2,  I_RDY,                    E_HSC},           // R2 to wbe stage
        {4'd2,  15'h0,                    E_HSC},           // R2 holds
        {4'd2,  I_WBE,                    E_HALT},          // R2 enter
        {4'd7,  I_AH,                     E_INQ},           // R7
        {4'd7,  I_BOFF,                   E_INQ},           // R7
        {4'd7,  15'h0,                    E_HALT},          // R7 back, no cycle
        {4'd8,  I_FLR,                    E_FLU},           // R8
        {4'd8,  15'h0,                    E_FLU},           // R8
        {4'd8,  I_FLD,                    E_HSC},           // R8 reissue
        {4'd2,  I_RDY | I_MASK,           E_HALT},          // R2 mask
        {4'd11, I_HALT | I_RDY,           E_HALT},          // R11
        {4'd5,  I_INTR,                   E_HALT},          // R5 masked intr
        {4'd5,  I_INTR | I_IEN,           E_NORM | C_INTR}, // R5
        {4'd6,  15'h0,                    E_NORM},          // R6 pulse ends
        {4'd1,  I_HALT,                   E_HSC},
        {4'd10, I_NMI,                    E_NORM | C_NMI},  // R10 cancel stage 1
        {4'd6,  15'h0,                    E_NORM},
        {4'd1,  I_HALT,                   E_HSC},
        {4'd2,  I_RDY,                    E_HSC},
        {4'd10, I_INIT,                   E_NORM | C_INIT}, // R10 cancel stage 2
        {4'd1,  I_HALT,                   E_HSC},
        {4'd2,  I_RDY | I_MASK,           E_HALT},
        {4'd6,  I_SMI | I_NMI | I_INTR | I_IEN, E_NORM | C_SMI}, // R6
        {4'd1,  I_HALT,                   E_HSC},
        {4'd2,  I_RDY | I_MASK,           E_HALT},
        {4'd6,  I_INIT | I_SMI,           E_NORM | C_INIT}, // R6
        {4'd1,  I_HALT,                   E_HSC},
        {4'd2,  I_RDY | I_MASK,           E_HALT},
        {4'd6,  I_RST | I_INIT | I_SMI | I_NMI | I_INTR | I_IEN, E_NORM | C_RST}, // R6
        {4'd1,  I_HALT,                   E_HSC},
        {4'd2,  I_RDY | I_MASK,           E_HALT},
        {4'd7,  I_HOLD | I_FLR,           E_INQ},           // R7 precedence
        {4'd7,  I_FLR,                    E_HALT},          // R7
        {4'd8,  I_FLR,                    E_FLU},           // R8
        {4'd5,  I_NMI,                    E_NORM | C_NMI}   // R5 from flush
    };

    task automatic drive(input logic [14:0] v);
        {halt_req, bus_rdy, wbuf_empty, wbe_wait_off, int_en, wake_reset, wake_init,
         wake_smi, wake_nmi, wake_intr, addr_hold, backoff, bus_hold, flush_req,
         flush_done} = v;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [9:0] outs();
        return {core_clk_en, halted, halt_cyc, inquire_busy, flush_busy, wake_cause};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL all-requirements watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [TW-1:0] t0;
        drive(15'h0);
        repeat (3) tick();
        // R9: block reset clears counter and selects normal outputs.
        check("R9 reset tsc", 32'(tsc), 32'd0);
        check("R3 reset outputs", 32'(outs()), 32'(E_NORM));
        rst_n = 1'b1;

        // Table walk.
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][24:10]);
            tick();
            check($sformatf("R%0d row %0d", VEC[i][28:25], i), 32'(outs()), 32'(VEC[i][9:0]));
        end

        // R4: counter keeps running while halted.
        drive(I_HALT); tick();
        drive(I_RDY | I_MASK); tick();
        drive(15'h0);
        t0 = tsc;
        repeat (10) tick();
        check("R4 count while halted", 32'(tsc), 32'(TW'(t0 + 8'd10)));
        check("R3 still halted", 32'(outs()), 32'(E_HALT));

        // R4: wrap from all ones to zero.
        for (int k = 0; k < 300 && tsc != {TW{1'b1}}; k++) tick();
        tick();
        check("R4 wrap", 32'(tsc), 32'd0);

        // R9: wake reset mid-handshake clears counter and cancels entry.
        drive(I_NMI); tick();
        drive(I_HALT); tick();
        drive(I_RDY); tick();
        drive(I_RST); tick();
        check("R9 tsc cleared", 32'(tsc), 32'd0);
        check("R9 normal with cause", 32'(outs()), 32'(E_NORM | C_RST));
        drive(15'h0); tick();
        check("R9 counts again", 32'(tsc), 32'd1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule